// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

This block is a bus-mapped timer peripheral with four counters. Three are down-counters of 16, 16 and 32 bits. Each one advances on one of two clock-enable strobes, chosen per timer. Each reloads or wraps when it underflows and raises a level interrupt that software acknowledges. The fourth counter is 40 bits wide and counts up on its own strobe. It never interrupts and is read through two 32-bit words. A latch makes the two halves of that read agree with each other.

Software talks to the unit over a simple single-cycle register bus. Writes take effect at the clock edge. Read data is combinational from the address. A read of the low word of the 40-bit counter has one side effect: at that edge it captures the upper bits. The tick strobes come from an external clock-enable generator. The interrupt lines go to an external interrupt controller.

Top module: `tmr_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register reads 0: load, value and control of each timer, the 40-bit counter, its latched upper bits and its enable. All three interrupt lines are low.
- R2: A write to a timer's load register stores the low W bits of the data, where W is 16 for timers 1 and 2 and 32 for timer 3. The same bits are copied into the counter at once. A read of the value register returns the live count, zero-extended to 32 bits.
- R3: While control bit 7 is 1, the counter decrements by one on each active tick of its selected source. Control bit 3 = 1 selects tick_fast and bit 3 = 0 selects tick_slow. The other strobe has no effect.
- R4: With control bit 6 = 1 (periodic mode), a tick that arrives while the count is 0 reloads the counter from the load register. A load value N therefore gives one underflow every N+1 ticks.
- R5: With control bit 6 = 0 (free mode), a tick that arrives while the count is 0 wraps the counter to all ones of its width. The underflow still raises the interrupt.
- R6: An underflow sets the timer's irq bit. The bit stays high until a write of any value to the clear register. An underflow in the same cycle as a clear write wins, and irq stays high.
- R7: While control bit 7 is 0, ticks are ignored and the count holds its value. It is not reset.
- R8: Timers 1, 2 and 3 have byte base addresses 0x00, 0x20 and 0x80, with offsets +0x0 load, +0x4 value, +0x8 control and +0xC clear. Control reads return bits 7, 6 and 3, with all other bits 0. The clear register reads 0. Writes to a value register are ignored. Any unmapped address reads 0.
- R9: The 40-bit counter resets to 0 and increments by one on each tick_free while its enable is 1. The enable is bit 8 of a write to address 0x64.
- R10: A read at 0x60 returns counter bits [31:0] and latches bits [39:32] at that edge. A read at 0x64 returns the latched byte in [7:0] and the enable in bit 8.
- R11: A load write in the same cycle as an active tick takes priority: the counter takes the written value and no underflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, used for the upper-bit latch |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| tick_slow | input | 1 | Slow tick strobe for timers 1-3 |
| tick_fast | input | 1 | Fast tick strobe for timers 1-3 |
| tick_free | input | 1 | Tick strobe for the 40-bit counter |
| irq | output | 3 | Interrupt levels, bit i for timer i+1 |

## Verification
The assertions check the following on every cycle:
- an underflow sets irq;
- a clear without an underflow drops irq;
- irq never rises without an underflow;
- a disabled counter holds;
- a load write overrides a tick;
- an underflow either reloads or wraps to all ones;
- the 40-bit counter steps by exactly one;
- the upper-bit latch captures the value seen at the low-word read.

Only the bench's scenarios can show the rest:
- the address map and control readback;
- the N+1 period as seen from the bus;
- selection between the two tick sources;
- the fact that writes to a value register leave it unchanged.

The bench compares the unit with a behavioural model under random reads, writes and ticks.

// File: rtl/tmr_pkg.sv
// Shared constants for the timer unit: address map, control bit positions.
// Assumes byte addressing on an 8-bit address with word-aligned registers.
package tmr_pkg;
    localparam int NUM_DN = 3;

    localparam logic [1:0] OFF_LOAD  = 2'd0;
    localparam logic [1:0] OFF_VALUE = 2'd1;
    localparam logic [1:0] OFF_CTRL  = 2'd2;
    localparam logic [1:0] OFF_CLR   = 2'd3;

    localparam int CB_EN   = 7;
    localparam int CB_PER  = 6;
    localparam int CB_FAST = 3;

    localparam logic [7:0] FREE_LO_ADDR = 8'h60;
    localparam logic [7:0] FREE_HI_ADDR = 8'h64;
    localparam int FREE_EN_BIT = 8;

    // Base address of down-counter i.
    function automatic logic [7:0] dn_base(input int i);
        case (i)
            0:       return 8'h00;
            1:       return 8'h20;
            default: return 8'h80;
        endcase
    endfunction
endpackage

// File: rtl/tmr_decode.sv
// Address decoder: turns bus strobes and address into per-register strobes.
// Assumes at most one of bus_wr / bus_rd per cycle; misaligned addresses miss.
module tmr_decode
    import tmr_pkg::*;
(
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    output logic [NUM_DN-1:0] sel_dn,
    output logic [NUM_DN-1:0] wr_load,
    output logic [NUM_DN-1:0] wr_ctrl,
    output logic [NUM_DN-1:0] wr_clr,
    output logic [1:0]        reg_off,
    output logic              sel_lo,
    output logic              sel_hi,
    output logic              wr_hi,
    output logic              rd_lo
);
    logic aligned;

    // Block hit and register offset for the down-counters.
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        reg_off = bus_addr[3:2];
        for (int i = 0; i < NUM_DN; i++) begin
            logic [7:0] b;
            b = dn_base(i);
            sel_dn[i]  = aligned && (bus_addr[7:4] == b[7:4]);
            wr_load[i] = bus_wr && sel_dn[i] && (reg_off == OFF_LOAD);
            wr_ctrl[i] = bus_wr && sel_dn[i] && (reg_off == OFF_CTRL);
            wr_clr[i]  = bus_wr && sel_dn[i] && (reg_off == OFF_CLR);
        end
    end

    // Strobes for the 40-bit counter words.
    always_comb begin
        sel_lo = (bus_addr == FREE_LO_ADDR);
        sel_hi = (bus_addr == FREE_HI_ADDR);
        wr_hi  = bus_wr && sel_hi;
        rd_lo  = bus_rd && sel_lo;
    end

    // R8: a write reaches at most one register.
    always_comb begin
        a_r8_one_target: assert ($onehot0({wr_load, wr_ctrl, wr_clr, wr_hi}));
    end
endmodule

// File: rtl/tmr_down.sv
// One reloading down-counter of width W (W <= 32), with load/control/irq.
// Assumes the tick strobes are single-cycle clock enables in the clk domain.
module tmr_down
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_slow,
    input  logic         tick_fast,
    input  logic         wr_load,
    input  logic         wr_ctrl,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    output logic [31:0]  load_o,
    output logic [31:0]  cnt_o,
    output logic [31:0]  ctrl_o,
    output logic         irq_o
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic [W-1:0] load_q;
    logic [W-1:0] cnt_q;
    logic         en_q, per_q, fast_q, irq_q;
    logic         tick_sel, step, uf;

    // Pick the tick source and detect an underflow.
    always_comb begin
        tick_sel = fast_q ? tick_fast : tick_slow;
        step     = en_q && tick_sel && !wr_load;
        uf       = step && (cnt_q == '0);
    end

    // Load register capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       load_q <= '0;
        else if (wr_load) load_q <= wdata;
    end

    // Counter: load write first, then reload/wrap on underflow, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (wr_load) cnt_q <= wdata;
        else if (uf)      cnt_q <= per_q ? load_q : ALL_ONES;
        else if (step)    cnt_q <= cnt_q - 1'b1;
    end

    // Control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            per_q  <= 1'b0;
            fast_q <= 1'b0;
        end else if (wr_ctrl) begin
            en_q   <= wdata[CB_EN];
            per_q  <= wdata[CB_PER];
            fast_q <= wdata[CB_FAST];
        end
    end

    // Interrupt level: underflow sets, clear write drops, underflow wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_q <= 1'b0;
        else if (uf)     irq_q <= 1'b1;
        else if (wr_clr) irq_q <= 1'b0;
    end

    // Register views for the read mux.
    always_comb begin
        load_o = 32'(load_q);
        cnt_o  = 32'(cnt_q);
        ctrl_o = '0;
        ctrl_o[CB_EN]   = en_q;
        ctrl_o[CB_PER]  = per_q;
        ctrl_o[CB_FAST] = fast_q;
        irq_o  = irq_q;
    end

    a_r6_set_on_uf: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && uf) |=> irq_q);
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_clr && !uf) |=> !irq_q);
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !irq_q && !uf) |=> !irq_q);
    a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !en_q && !wr_load) |=> $stable(cnt_q));
    a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_load) |=> (cnt_q == $past(wdata)));
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && uf && per_q) |=> (cnt_q == $past(load_q)));
    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && uf && !per_q) |=> (&cnt_q));
endmodule

// File: rtl/tmr_free.sv
// Free-running up-counter of width W (32 < W <= 40) with a split read.
// Reading the low word latches the upper bits for a coherent high-word read.
module tmr_free
    import tmr_pkg::*;
#(
    parameter int W = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_hi,
    input  logic        en_wdata,
    input  logic        rd_lo,
    output logic [31:0] lo_o,
    output logic [31:0] hi_o
);
    localparam int HI_W = W - 32;

    logic [W-1:0]    cnt_q;
    logic [HI_W-1:0] hi_q;
    logic            en_q;

    // Enable bit, written through the high word.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (wr_hi) en_q <= en_wdata;
    end

    // Count up on each tick while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (en_q && tick)  cnt_q <= cnt_q + 1'b1;
    end

    // Capture the upper bits when the low word is read.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_q <= '0;
        else if (rd_lo) hi_q <= cnt_q[W-1:32];
    end

    // Read views.
    always_comb begin
        lo_o = cnt_q[31:0];
        hi_o = '0;
        hi_o[7:0]         = 8'(hi_q);
        hi_o[FREE_EN_BIT] = en_q;
    end

    a_r9_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && en_q && tick) |=> (cnt_q == $past(cnt_q) + 1'b1));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !(en_q && tick)) |=> $stable(cnt_q));
    a_r10_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && rd_lo) |=> (hi_q == $past(cnt_q[W-1:32])));
endmodule

// File: rtl/tmr_unit.sv
// Timer unit top: decoder, three down-counters, one 40-bit counter, read mux.
// Assumes single-cycle bus writes and combinational reads.
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int T1_W   = 16,
    parameter int T2_W   = 16,
    parameter int T3_W   = 32,
    parameter int FREE_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_slow,
    input  logic              tick_fast,
    input  logic              tick_free,
    output logic [NUM_DN-1:0] irq
);
    logic [NUM_DN-1:0] sel_dn, wr_load, wr_ctrl, wr_clr;
    logic [1:0]        reg_off;
    logic              sel_lo, sel_hi, wr_hi, rd_lo;
    logic [31:0]       load_w [NUM_DN];
    logic [31:0]       cnt_w  [NUM_DN];
    logic [31:0]       ctrl_w [NUM_DN];
    logic [31:0]       lo_w, hi_w;

    tmr_decode u_dec (
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .bus_addr(bus_addr),
        .sel_dn  (sel_dn),
        .wr_load (wr_load),
        .wr_ctrl (wr_ctrl),
        .wr_clr  (wr_clr),
        .reg_off (reg_off),
        .sel_lo  (sel_lo),
        .sel_hi  (sel_hi),
        .wr_hi   (wr_hi),
        .rd_lo   (rd_lo)
    );

    for (genvar g = 0; g < NUM_DN; g++) begin : g_dn
        localparam int W = (g == 0) ? T1_W : (g == 1) ? T2_W : T3_W;
        tmr_down #(.W(W)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_slow(tick_slow),
            .tick_fast(tick_fast),
            .wr_load  (wr_load[g]),
            .wr_ctrl  (wr_ctrl[g]),
            .wr_clr   (wr_clr[g]),
            .wdata    (bus_wdata[W-1:0]),
            .load_o   (load_w[g]),
            .cnt_o    (cnt_w[g]),
            .ctrl_o   (ctrl_w[g]),
            .irq_o    (irq[g])
        );
    end

    tmr_free #(.W(FREE_W)) u_free (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_free),
        .wr_hi   (wr_hi),
        .en_wdata(bus_wdata[FREE_EN_BIT]),
        .rd_lo   (rd_lo),
        .lo_o    (lo_w),
        .hi_o    (hi_w)
    );

    // Read mux; unmapped addresses and the clear registers return zero.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_DN; i++) begin
            if (sel_dn[i]) begin
                case (reg_off)
                    OFF_LOAD:  bus_rdata = load_w[i];
                    OFF_VALUE: bus_rdata = cnt_w[i];
                    OFF_CTRL:  bus_rdata = ctrl_w[i];
                    default:   bus_rdata = '0;
                endcase
            end
        end
        if (sel_lo) bus_rdata = lo_w;
        if (sel_hi) bus_rdata = hi_w;
    end
endmodule

// File: tb/tmr_unit_tb.sv
// Self-checking bench: directed corners, then seeded random traffic vs. a model.
module tmr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd, tick_slow, tick_fast, tick_free;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [2:0]  irq;

    always #4 clk = ~clk;

    tmr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_slow(tick_slow), .tick_fast(tick_fast), .tick_free(tick_free),
        .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Behavioural model state.
    logic [31:0] m_load [3];
    logic [31:0] m_cnt  [3];
    logic        m_en [3], m_per [3], m_fast [3], m_irq [3];
    logic [39:0] m_c4;
    logic        m_en4;
    logic [7:0]  m_hi;

    function automatic logic [31:0] msk(input int i);
        return (i == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    function automatic logic [7:0] base(input int i);
        return (i == 0) ? 8'h00 : (i == 1) ? 8'h20 : 8'h80;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        for (int i = 0; i < 3; i++) begin
            if (a == base(i))         return m_load[i];
            if (a == base(i) + 8'd4)  return m_cnt[i];
            if (a == base(i) + 8'd8)  return {24'b0, m_en[i], m_per[i], 2'b0, m_fast[i], 3'b0};
            if (a == base(i) + 8'd12) return 32'h0;
        end
        if (a == 8'h60) return m_c4[31:0];
        if (a == 8'h64) return {23'b0, m_en4, m_hi};
        return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_update(input logic wr, rd, input logic [7:0] a,
                                input logic [31:0] d, input logic ts, tf, tfr);
        for (int i = 0; i < 3; i++) begin
            logic wl, wc, wcl, tk, uf;
            wl  = wr && (a == base(i));
            wc  = wr && (a == base(i) + 8'd8);
            wcl = wr && (a == base(i) + 8'd12);
            tk  = m_fast[i] ? tf : ts;
            uf  = 1'b0;
            if (wl) begin
                m_cnt[i]  = d & msk(i);
                m_load[i] = d & msk(i);
            end else if (m_en[i] && tk) begin
                if (m_cnt[i] == 0) begin
                    uf = 1'b1;
                    m_cnt[i] = m_per[i] ? m_load[i] : msk(i);
                end else begin
                    m_cnt[i] = m_cnt[i] - 1;
                end
            end
            if (wc) begin
                m_en[i] = d[7]; m_per[i] = d[6]; m_fast[i] = d[3];
            end
            if (uf) m_irq[i] = 1'b1;
            else if (wcl) m_irq[i] = 1'b0;
        end
        if (rd && a == 8'h60) m_hi = m_c4[39:32];
        if (m_en4 && tfr) m_c4 = m_c4 + 1;
        if (wr && a == 8'h64) m_en4 = d[8];
    endtask

    // One bus cycle: drive at negedge, check reads and irq, advance the model.
    task automatic step(input logic wr, rd, input logic [7:0] a, input logic [31:0] d,
                        input logic ts, tf, tfr, input string tag);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        tick_slow = ts; tick_fast = tf; tick_free = tfr;
        #1;
        if (rd) check(tag, bus_rdata, exp_rd(a));
        check("R6 irq", {29'b0, irq}, {29'b0, m_irq[2], m_irq[1], m_irq[0]});
        model_update(wr, rd, a, d, ts, tf, tfr);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(1'b0, 1'b1, a, 32'h0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(1'b1, 1'b0, a, d, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic tk(input logic ts, tf, tfr, input string tag);
        step(1'b0, 1'b0, 8'h40, 32'h0, ts, tf, tfr, tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] pool [16];
        void'($urandom(32'd20240611));
        pool = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h20, 8'h24, 8'h28, 8'h2C,
                 8'h80, 8'h84, 8'h88, 8'h8C, 8'h60, 8'h64, 8'h40, 8'h61};
        for (int i = 0; i < 3; i++) begin
            m_load[i] = 0; m_cnt[i] = 0; m_en[i] = 0; m_per[i] = 0; m_fast[i] = 0; m_irq[i] = 0;
        end
        m_c4 = 0; m_en4 = 0; m_hi = 0;
        rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        tick_slow = 0; tick_fast = 0; tick_free = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state of every register.
        for (int k = 0; k < 16; k++) rd(pool[k], "R1 reset read");

        // R2: load copies into counter, width-masked.
        wr(8'h00, 32'h0001_2345, "R2");
        rd(8'h00, "R2 load t1");
        rd(8'h04, "R2 value t1");
        wr(8'h80, 32'hDEAD_BEEF, "R2");
        rd(8'h84, "R2 value t3");

        // R8: value write ignored, unmapped read, control readback.
        wr(8'h04, 32'h0000_0055, "R8");
        rd(8'h04, "R8 value write ignored");
        rd(8'h40, "R8 unmapped");
        wr(8'h08, 32'hFFFF_FFFF, "R8");
        rd(8'h08, "R8 ctrl readback");

        // R3: fast source counts, slow source ignored.
        repeat (3) tk(1'b0, 1'b1, 1'b0, "R3");
        rd(8'h04, "R3 fast ticks");
        repeat (2) tk(1'b1, 1'b0, 1'b0, "R3");
        rd(8'h04, "R3 other source ignored");

        // R7: disabled counter holds.
        wr(8'h08, 32'h0000_0048, "R7");
        repeat (4) tk(1'b1, 1'b1, 1'b0, "R7");
        rd(8'h04, "R7 frozen");

        // R4: periodic reload, period N+1.
        wr(8'h20, 32'd2, "R4");
        wr(8'h28, 32'h0000_00C0, "R4");
        repeat (3) tk(1'b1, 1'b0, 1'b0, "R4");
        rd(8'h24, "R4 reloaded");
        rd(8'h2C, "R8 clear reads zero");
        wr(8'h2C, 32'h0, "R6 clear");
        rd(8'h24, "R6 after clear");

        // R6: underflow in the same cycle as clear keeps irq.
        repeat (2) tk(1'b1, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b0, 8'h2C, 32'h0, 1'b1, 1'b0, 1'b0, "R6 clear+uf");
        tk(1'b0, 1'b0, 1'b0, "R6 irq held");

        // R5: free mode wraps to all ones.
        wr(8'h88, 32'h0000_0080, "R5");
        wr(8'h80, 32'h0, "R5");
        tk(1'b1, 1'b0, 1'b0, "R5");
        rd(8'h84, "R5 wrap t3");

        // R11: load write beats a simultaneous tick.
        step(1'b1, 1'b0, 8'h80, 32'h10, 1'b1, 1'b0, 1'b0, "R11");
        rd(8'h84, "R11 load wins");

        // R9, R10: 40-bit counter enable, count and split read.
        wr(8'h64, 32'h0000_0100, "R9");
        repeat (5) tk(1'b0, 1'b0, 1'b1, "R9");
        rd(8'h60, "R10 low word");
        rd(8'h64, "R10 high word");
        wr(8'h64, 32'h0, "R9");
        repeat (3) tk(1'b0, 1'b0, 1'b1, "R9");
        rd(8'h60, "R9 disabled holds");

        // Random traffic covering R3, R4, R5, R6, R7, R11.
        for (int n = 0; n < 4000; n++) begin
            int op;
            logic [7:0] a;
            logic [31:0] d;
            op = $urandom_range(0, 9);
            a  = pool[$urandom_range(0, 15)];
            d  = $urandom();
            if (a == 8'h00 || a == 8'h20 || a == 8'h80) d = d & 32'h0000_001F;
            if (op < 2)
                step(1'b1, 1'b0, a, d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), "random write");
            else
                step(1'b0, 1'($urandom_range(0, 1)), a, 32'h0, 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "random read");
        end
        tk(1'b0, 1'b0, 1'b0, "final");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule